// File: doc/BRIEF.md
# Dual 8-bit Timer with Compare, PWM and 16-bit Cascade

This block holds two 8-bit up-counters, each with its own compare byte, control byte, interrupt pulse and output pin. A channel advances once for each single-cycle strobe on its count-enable input. An external clock selector supplies that strobe. In each cycle the channel may clear or wrap. In the compare modes it pulses its interrupt when the count reaches the compare value. In PWM mode it drives a pulse-width waveform on its pin.

Setting the cascade bit joins the two channels into one 16-bit timer. The low channel's strobe, enable and mode then drive both bytes. The high byte steps when the low byte overflows, and the compare covers all 16 bits. Software reads the two count bytes with separate accesses. The bytes may therefore come from different counts, so software reads twice and compares.

The register map on the 8-bit bus is as follows. Address 0 is the control byte of channel 0, address 1 is its compare byte, and address 2 is its count. Addresses 4, 5 and 6 hold the same three registers for channel 1. The control byte fields are:
- bit 0: enable.
- bits 2:1: mode. 00 is clear-and-start, 01 is free-running compare, and 1x is PWM.
- bit 3: cascade. This bit is used only in channel 1's control byte.
- bit 4: PWM polarity. 1 makes the active level high.

Top module: `dual_timer8`

## Requirements
- R1: While a channel is enabled, its count rises by one on each clock where its strobe is high and holds on every other clock. In free-running mode the count wraps from FFh to 00h.
- R2: Reset sets every count to 00h. A count also reads 00h from the clock after its channel's enable bit is found clear.
- R3: In clear-and-start mode, the first strobe after the count equals the compare byte returns the count to 00h. The cycle therefore takes the compare value plus one strobes.
- R4: In the two compare modes, a strobe that brings the count to the compare value raises that channel's interrupt for exactly one clock. This is the first clock in which the new count is visible. An interrupt never appears without a strobe in the previous clock.
- R5: In PWM mode, the strobe that moves the count from FFh to 00h makes the output active. The strobe that brings the count to the compare value makes it inactive. When both happen on one strobe (compare 00h), the inactive level wins. PWM mode raises no interrupt.
- R6: A polarity bit of 1 gives an active-high output, and 0 gives an active-low output. A disabled channel drives its inactive level, and so do both channels after reset.
- R7: When the cascade bit is set, the high count byte steps on each low-channel strobe that finds the low byte at FFh. Channel 1's strobe and enable are ignored, and both pins rest at their inactive level.
- R8: In cascade mode, the 16-bit count is compared with {compare1, compare0}. A match pulses only interrupt 0. In clear-and-start mode, the first strobe after a match clears both bytes.
- R9: In cascade mode, clearing channel 0's enable bit zeroes both count bytes.
- R10: The compare and control bytes read back what was last written, over the full range 00h to FFh. The count addresses are read-only, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| tick_i | input | 2 | Count-enable strobes, one bit per channel |
| irq_o | output | 2 | Interrupt pulses, one bit per channel |
| tout_o | output | 2 | Timer output pins, one bit per channel |

## Verification
The bench targets four boundaries:
- The clear-and-start boundary. A design that clears on reaching the compare value, instead of on the next strobe, shortens every cycle by one and never shows the compare value.
- PWM with a compare of 00h. The output must stay inactive there, and a wrong priority between overflow and match would leave it active for a full period.
- Cascade operation while channel 1's own strobe is toggling. A high byte that took that strobe, or a compare that matched on the low byte alone, would show up as a wrong count or as an early or misplaced interrupt.
- The count addresses. Writes to them must not change the counts, and disabling channel 0 must clear the high byte too.

// File: rtl/dual_timer8.sv
`timescale 1ns/1ps
module dual_timer8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic [2:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [1:0]   tick_i,
  output logic [1:0]   irq_o,
  output logic [1:0]   tout_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] ctl0, ctl1, cmp0, cmp1, cnt0, cnt1;
  logic         lvl0, lvl1;

  wire       casc  = ctl1[3];
  wire       en0   = ctl0[0];
  wire       en1   = casc ? ctl0[0] : ctl1[0];
  wire [1:0] md0   = ctl0[2:1];
  wire [1:0] md1   = casc ? ctl0[2:1] : ctl1[2:1];

  wire hit0  = casc ? ({cnt1, cnt0} == {cmp1, cmp0}) : (cnt0 == cmp0);
  wire clr0  = (md0 == 2'b00) && hit0;
  wire clr1  = casc ? clr0 : ((md1 == 2'b00) && (cnt1 == cmp1));
  wire step0 = tick_i[0] && en0;
  wire step1 = casc ? step0 && (clr0 || cnt0 == TOP) : tick_i[1] && en1;

  wire [W-1:0] nx0 = clr0 ? '0 : cnt0 + 1'b1;
  wire [W-1:0] nx1 = clr1 ? '0 : cnt1 + 1'b1;
  wire [W-1:0] hi_after = step1 ? nx1 : cnt1;
  wire match0 = casc ? ({hi_after, nx0} == {cmp1, cmp0}) : (nx0 == cmp0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl0 <= '0; ctl1 <= '0; cmp0 <= '0; cmp1 <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        3'd0: ctl0 <= bus_wdata;
        3'd1: cmp0 <= bus_wdata;
        3'd4: ctl1 <= bus_wdata;
        3'd5: cmp1 <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en0)  cnt0 <= '0;
    else if (step0)      cnt0 <= nx0;
    if (!rst_n || !en1)  cnt1 <= '0;
    else if (step1)      cnt1 <= nx1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= '0;
    end else begin
      irq_o[0] <= step0 && !md0[1] && match0;
      irq_o[1] <= !casc && step1 && !md1[1] && (nx1 == cmp1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en0 || !md0[1] || casc) lvl0 <= 1'b0;
    else if (step0) lvl0 <= (nx0 == cmp0) ? 1'b0 : (cnt0 == TOP) ? 1'b1 : lvl0;
    if (!rst_n || !en1 || !md1[1] || casc) lvl1 <= 1'b0;
    else if (step1) lvl1 <= (nx1 == cmp1) ? 1'b0 : (cnt1 == TOP) ? 1'b1 : lvl1;
  end

  assign tout_o = {lvl1 ^ ~ctl1[4], lvl0 ^ ~ctl0[4]};

  always_comb begin
    case (bus_addr)
      3'd0: bus_rdata = ctl0;
      3'd1: bus_rdata = cmp0;
      3'd2: bus_rdata = cnt0;
      3'd4: bus_rdata = ctl1;
      3'd5: bus_rdata = cmp1;
      3'd6: bus_rdata = cnt1;
      default: bus_rdata = '0;
    endcase
  end

  AST_DIS_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) !en0 |=> cnt0 == '0); // R2
  AST_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) (en0 && !tick_i[0]) |=> cnt0 == $past(cnt0)); // R1
  AST_IRQ_CAUSE:  assert property (@(posedge clk) disable iff (!rst_n) irq_o[0] |-> $past(tick_i[0])); // R4
  AST_CASC_IRQ1:  assert property (@(posedge clk) disable iff (!rst_n) (casc && $past(casc)) |-> !irq_o[1]); // R8
  AST_REST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) $past(!en0) |-> tout_o[0] == ~ctl0[4]); // R6
endmodule

// File: tb/dual_timer8_test.sv
`timescale 1ns/1ps
module dual_timer8_test;
  logic       clk = 0, rst_n = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [1:0] tick_i = 0, irq_o, tout_o;
  int checks = 0, fails = 0, irq0_seen = 0, irq1_seen = 0;
  bit done = 0;

  dual_timer8 uut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i), .irq_o(irq_o), .tout_o(tout_o));

  always #2 clk = ~clk;

  // {strobe, expected count0, expected irq0}: clear-and-start, compare 3
  localparam logic [9:0] VEC [10] = '{
    {1'b1, 8'd1, 1'b0}, {1'b0, 8'd1, 1'b0}, {1'b1, 8'd2, 1'b0}, {1'b1, 8'd3, 1'b1},
    {1'b0, 8'd3, 1'b0}, {1'b1, 8'd0, 1'b0}, {1'b1, 8'd1, 1'b0}, {1'b1, 8'd2, 1'b0},
    {1'b1, 8'd3, 1'b1}, {1'b1, 8'd0, 1'b0}};

  task automatic step(); @(posedge clk); @(negedge clk); endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d; step(); bus_we = 0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask
  task automatic pulse(input logic [1:0] m);
    tick_i = m; step(); tick_i = 0;
    irq0_seen += int'(irq_o[0]); irq1_seen += int'(irq_o[1]);
  endtask
  task automatic pulses(input int n, input logic [1:0] m);
    for (int i = 0; i < n; i++) pulse(m);
  endtask
  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, hi;
    @(negedge clk); step(); step(); rst_n = 1; step();
    rd(3'd2, d); check("R2 reset count0", d, 0);
    check("R4 reset irq", irq_o, 0);
    check("R6 reset rest level", tout_o, 2'b11);

    wr(3'd1, 8'd3); wr(3'd0, 8'h01); step();
    foreach (VEC[i]) begin
      pulse({1'b0, VEC[i][9]});
      rd(3'd2, d);
      check("R3 clear-start count", d, VEC[i][8:1]);
      check("R4 clear-start irq", irq_o[0], VEC[i][0]);
    end

    wr(3'd1, 8'h10); wr(3'd0, 8'h00); step(); wr(3'd0, 8'h03); step();
    irq0_seen = 0;
    pulses(15, 2'b01); check("R4 no early irq", irq0_seen, 0);
    pulse(2'b01); check("R4 free-run irq", irq_o[0], 1);
    rd(3'd2, d); check("R1 free-run count", d, 8'h10);
    step(); check("R4 one-cycle irq", irq_o[0], 0);
    wr(3'd2, 8'h55); rd(3'd2, d); check("R10 count read-only", d, 8'h10);
    pulses(240, 2'b01); rd(3'd2, d); check("R1 wrap to 00", d, 0);
    pulses(5, 2'b01);
    wr(3'd0, 8'h02); step(); rd(3'd2, d); check("R2 disable clears", d, 0);
    wr(3'd1, 8'hFF); rd(3'd1, d); check("R10 compare readback", d, 8'hFF);
    rd(3'd0, d); check("R10 control readback", d, 8'h02);

    wr(3'd5, 8'd4); wr(3'd4, 8'h15); step();
    check("R6 pwm starts inactive", tout_o[1], 0);
    irq1_seen = 0;
    pulses(4, 2'b10); check("R5 match inactive", tout_o[1], 0);
    pulses(251, 2'b10); rd(3'd6, d); check("R1 ch1 at FF", d, 8'hFF);
    check("R5 still inactive", tout_o[1], 0);
    pulse(2'b10); check("R5 overflow active", tout_o[1], 1);
    pulses(3, 2'b10); check("R5 active until match", tout_o[1], 1);
    pulse(2'b10); check("R5 match clears", tout_o[1], 0);
    check("R5 no pwm irq", irq1_seen, 0);
    wr(3'd4, 8'h14); step(); check("R6 disabled high-pol", tout_o[1], 0);
    wr(3'd4, 8'h04); step(); check("R6 disabled low-pol", tout_o[1], 1);
    wr(3'd5, 8'd0); wr(3'd4, 8'h15); step();
    pulses(256, 2'b10); check("R5 compare 00 match wins", tout_o[1], 0);

    wr(3'd0, 8'h00); wr(3'd4, 8'h08); wr(3'd1, 8'h05); wr(3'd5, 8'h01);
    wr(3'd0, 8'h11); step();
    irq0_seen = 0; irq1_seen = 0;
    pulses(255, 2'b11);
    rd(3'd2, d); rd(3'd6, hi); check("R7 cascade hold high", {hi, d}, 16'h00FF);
    pulse(2'b11);
    rd(3'd2, d); rd(3'd6, hi); check("R7 cascade carry", {hi, d}, 16'h0100);
    check("R8 no low-byte-only irq", irq0_seen, 0);
    check("R7 cascade pins inactive", tout_o, 2'b10);
    pulses(4, 2'b11); check("R8 no irq before match", irq0_seen, 0);
    pulse(2'b11); check("R8 16-bit irq", irq_o[0], 1);
    check("R8 irq1 silent", irq1_seen, 0);
    pulse(2'b11);
    rd(3'd2, d); rd(3'd6, hi); check("R8 cascade clear", {hi, d}, 16'h0000);
    pulses(258, 2'b11);
    rd(3'd2, d); rd(3'd6, hi); check("R7 cascade count", {hi, d}, 16'h0102);
    wr(3'd0, 8'h10); step();
    rd(3'd2, d); rd(3'd6, hi); check("R9 disable zeroes both", {hi, d}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule